// File: doc/BRIEF.md
# Wide-Register Fixed-Point Multiply-Accumulator

This block multiplies two 32-bit fixed-point operands and keeps an 80-bit local result register. The result register is built from a 16-bit guard word (bits 79..64), a 32-bit upper word (bits 63..32) and a 32-bit lower word (bits 31..0). Each operand's signedness is picked separately. One format control picks integer or fractional data for the whole operation. Fractional results live in the upper word. Integer results live in the lower word.

One operation is accepted per clock. The operations are multiply, multiply-add, multiply-subtract, clear, round and saturate. Each operation either updates the result register or leaves it alone. In both cases the 32-bit result word appears on a registered output one cycle later. A side port reads or writes the three sub-words one at a time. Negative, overflow and underflow status flags are kept, along with a sticky overflow flag. Software can overwrite the status flags and the sticky flag directly.

Top module: `fxp_mac_acc`

## Requirements
- R1: While reset is asserted, the result register, the status flags, the sticky flag, `res_out` and `res_vld` are all zero.
- R2: `op_code` 1 (multiply) forms the 80-bit product. Each operand is read as signed or unsigned according to its own control. When `frac` is set and both operands are signed, the product is doubled (shifted left one bit).
- R3: `op_code` 2 adds the product to the register and `op_code` 3 subtracts it. Both wrap modulo 2^80. The returned word is bits 63..32 when `frac` is set and bits 31..0 otherwise.
- R4: When `to_reg` is 0, an arithmetic operation (codes 1, 2, 3, 5, 6) leaves the register unchanged. It still returns its 32-bit word on `res_out` with `res_vld` high one cycle later.
- R5: `op_code` 4 zeroes the whole register and the three status flags, whatever `to_reg` is. `res_out` becomes 0.
- R6: Rounding applies to `op_code` 5, or to codes 1..3 when `rnd_req` is set, and only when `frac` is set. It adds the value of bit 31 at bit 32, but a remainder of exactly 2^31 rounds to an even bit 32. The lower word is then cleared. An integer value is not changed.
- R7: `op_code` 6 replaces an overflowed value with a limit chosen by `frac` and `x_signed`. The signed fractional limits are 0000_7FFFFFFF_FFFFFFFF and FFFF_80000000_00000000. The signed integer limits are 0000_00000000_7FFFFFFF and FFFF_FFFFFFFF_80000000. The unsigned fractional limit is 0000_FFFFFFFF_FFFFFFFF and the unsigned integer limit is 0000_00000000_FFFFFFFF. Any unsigned overflow loads the unsigned limit. A value that has not overflowed is kept.
- R8: `flags_out` bit 7 (overflow) is set when the value before saturation leaves the selected format. Signed fractional allows -2^63..2^63-1, unsigned fractional 0..2^64-1, signed integer -2^31..2^31-1 and unsigned integer 0..2^32-1. Bit 6 (negative) copies bit 79 of the resulting value.
- R9: `flags_out` bit 8 (underflow) is set by a fractional operation when the returned word is zero but bits 31..0 of the value before rounding are not.
- R10: `sticky_out` bit 6 is set by any arithmetic overflow and holds until it is written. No other bit of `flags_out` or `sticky_out` is ever set.
- R11: `stat_wr_en` loads `flags_out` bits 8..6 from `stat_wr_data` bits 8..6, and `stky_wr_en` loads `sticky_out` bit 6 from `stky_wr_data` bit 6. In the same cycle, each write takes priority over the update from the operation.
- R12: With `op_valid` low and `wr_en` high, `wr_sel` picks the sub-word to load from `wr_data`: 0 loads the lower word, 1 loads the upper word and fills bits 79..64 with `wr_data[31]`, and 2 loads the guard word from `wr_data[15:0]`. While `op_valid` is high, `wr_en` is ignored.
- R13: `rd_data` shows the sub-word picked by `rd_sel`: 0 the lower word, 1 the upper word, 2 the guard word sign-extended to 32 bits, and 3 returns zero. Operation codes 0 and 7 change nothing and leave `res_vld` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation select (0 none, 1 mul, 2 mul-add, 3 mul-sub, 4 clear, 5 round, 6 saturate) |
| to_reg | input | 1 | Write the result back into the register |
| x_signed | input | 1 | X operand signed; also picks the signed limits for round and saturate |
| y_signed | input | 1 | Y operand signed |
| frac | input | 1 | Fractional format (1) or integer format (0) |
| rnd_req | input | 1 | Round the result of a multiply operation |
| x_in | input | 32 | X operand |
| y_in | input | 32 | Y operand |
| wr_en | input | 1 | Sub-word write strobe |
| wr_sel | input | 2 | Sub-word to write |
| wr_data | input | 32 | Sub-word write data |
| rd_sel | input | 2 | Sub-word to read |
| rd_data | output | 32 | Selected sub-word |
| stat_wr_en | input | 1 | Direct load of the status flags |
| stat_wr_data | input | 9 | Status load value (bits 8..6 used) |
| stky_wr_en | input | 1 | Direct load of the sticky flag |
| stky_wr_data | input | 9 | Sticky load value (bit 6 used) |
| flags_out | output | 9 | Status flags: 6 negative, 7 overflow, 8 underflow |
| sticky_out | output | 9 | Sticky flags: 6 overflow |
| res_out | output | 32 | Returned result word |
| res_vld | output | 1 | `res_out` was updated by the last operation |

## Verification
The bench builds the block with its default widths: 32-bit operands and a 16-bit guard word, which gives the full 80-bit register. At these widths every saturation limit can be reached. So can a round-half tie at bit 32, a wrap of multiply-add chains past bit 79, and the sign fill of the guard word on reads and upper-word writes. The reference model works in 128-bit signed arithmetic, so it can hold the largest unsigned product and its accumulations without losing any bits.

// File: rtl/fxp_mac_pkg.sv
package fxp_mac_pkg;

  typedef enum logic [2:0] {
    MOP_NOP = 3'd0,
    MOP_MUL = 3'd1,
    MOP_MAC = 3'd2,
    MOP_MSB = 3'd3,
    MOP_CLR = 3'd4,
    MOP_RND = 3'd5,
    MOP_SAT = 3'd6
  } mac_op_e;

  typedef enum logic [1:0] {
    SUB_LO  = 2'd0,
    SUB_MID = 2'd1,
    SUB_TOP = 2'd2
  } sub_sel_e;

  localparam int FLG_W   = 9;
  localparam int FLG_NEG = 6;
  localparam int FLG_OVF = 7;
  localparam int FLG_UNF = 8;
  localparam int STK_OVF = 6;

endpackage

// File: rtl/fxp_mac_mul.sv
module fxp_mac_mul #(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 80
) (
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              x_sgn_i,
  input  logic              y_sgn_i,
  input  logic              frac_i,
  output logic [ACC_W-1:0]  prod_o
);
  localparam int PW = 2*DATA_W + 2;

  logic signed [DATA_W:0] xe, ye;
  logic signed [PW-1:0]   xw, yw, p;
  logic [ACC_W-1:0]       pext;

  always_comb begin
    xe   = {x_sgn_i & x_i[DATA_W-1], x_i};
    ye   = {y_sgn_i & y_i[DATA_W-1], y_i};
    xw   = PW'(xe);
    yw   = PW'(ye);
    p    = xw * yw;
    pext = {{(ACC_W-PW){p[PW-1]}}, p};
    // signed fractional operands carry a redundant sign bit
    prod_o = (frac_i & x_sgn_i & y_sgn_i) ? (pext << 1) : pext;
  end
endmodule

// File: rtl/fxp_mac_cond.sv
module fxp_mac_cond #(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 80
) (
  input  logic [ACC_W-1:0]  val_i,
  input  logic              rnd_i,
  input  logic              sat_i,
  input  logic              frac_i,
  input  logic              sgn_i,
  output logic [ACC_W-1:0]  res_o,
  output logic [DATA_W-1:0] word_o,
  output logic              ovf_o,
  output logic              neg_o,
  output logic              unf_o
);
  localparam int HI_W = ACC_W - DATA_W;

  logic [DATA_W-1:0] lo;
  logic              up;
  logic [ACC_W-1:0]  rv, pos_lim, hi_mask, hi_bits;
  int                lim_bits;

  always_comb begin
    lo = val_i[DATA_W-1:0];
    up = lo[DATA_W-1] & ((|lo[DATA_W-2:0]) | val_i[DATA_W]);
    rv = (rnd_i & frac_i) ? {val_i[ACC_W-1:DATA_W] + HI_W'(up), {DATA_W{1'b0}}}
                          : val_i;

    lim_bits = (frac_i ? 2*DATA_W : DATA_W) - (sgn_i ? 1 : 0);
    pos_lim  = {ACC_W{1'b1}} >> (ACC_W - lim_bits);
    hi_mask  = ~pos_lim;
    hi_bits  = rv & hi_mask;
    ovf_o    = sgn_i ? !((hi_bits == '0) || (hi_bits == hi_mask))
                     : (hi_bits != '0);

    if (sat_i && ovf_o)
      res_o = (sgn_i && rv[ACC_W-1]) ? ~pos_lim : pos_lim;
    else
      res_o = rv;

    word_o = frac_i ? res_o[2*DATA_W-1:DATA_W] : res_o[DATA_W-1:0];
    neg_o  = res_o[ACC_W-1];
    unf_o  = frac_i && (word_o == '0) && (lo != '0);
  end
endmodule

// File: rtl/fxp_mac_port.sv
module fxp_mac_port
  import fxp_mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TOP_W  = 16,
  parameter int ACC_W  = TOP_W + 2*DATA_W
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_sel_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic [DATA_W-1:0] rd_o
);
  logic [TOP_W-1:0]  top;
  logic [DATA_W-1:0] top_rd;

  assign top = acc_i[ACC_W-1:2*DATA_W];

  generate
    if (TOP_W < DATA_W) begin : g_ext
      assign top_rd = {{(DATA_W-TOP_W){top[TOP_W-1]}}, top};
    end else begin : g_trunc
      assign top_rd = top[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    acc_o = acc_i;
    if (wr_en_i) begin
      case (wr_sel_i)
        SUB_LO:  acc_o[DATA_W-1:0] = wr_data_i;
        SUB_MID: begin
          acc_o[2*DATA_W-1:DATA_W]    = wr_data_i;
          acc_o[ACC_W-1:2*DATA_W]     = {TOP_W{wr_data_i[DATA_W-1]}};
        end
        SUB_TOP: acc_o[ACC_W-1:2*DATA_W] = TOP_W'(wr_data_i);
        default: ;
      endcase
    end
    case (rd_sel_i)
      SUB_LO:  rd_o = acc_i[DATA_W-1:0];
      SUB_MID: rd_o = acc_i[2*DATA_W-1:DATA_W];
      SUB_TOP: rd_o = top_rd;
      default: rd_o = '0;
    endcase
  end
endmodule

// File: rtl/fxp_mac_acc.sv
module fxp_mac_acc
  import fxp_mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TOP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic              to_reg,
  input  logic              x_signed,
  input  logic              y_signed,
  input  logic              frac,
  input  logic              rnd_req,
  input  logic [DATA_W-1:0] x_in,
  input  logic [DATA_W-1:0] y_in,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              stat_wr_en,
  input  logic [FLG_W-1:0]  stat_wr_data,
  input  logic              stky_wr_en,
  input  logic [FLG_W-1:0]  stky_wr_data,
  output logic [FLG_W-1:0]  flags_out,
  output logic [FLG_W-1:0]  sticky_out,
  output logic [DATA_W-1:0] res_out,
  output logic              res_vld
);
  localparam int ACC_W = TOP_W + 2*DATA_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  mac_op_e op;
  logic    arith, clr, mul_like, do_rnd, do_sat;
  assign op       = mac_op_e'(op_code);
  assign mul_like = (op == MOP_MUL) || (op == MOP_MAC) || (op == MOP_MSB);
  assign arith    = op_valid && (mul_like || (op == MOP_RND) || (op == MOP_SAT));
  assign clr      = op_valid && (op == MOP_CLR);
  assign do_rnd   = (op == MOP_RND) || (rnd_req && mul_like);
  assign do_sat   = (op == MOP_SAT);

  logic [ACC_W-1:0]  acc_q, acc_d, prod, base, cond_res, port_acc;
  logic [DATA_W-1:0] cond_word;
  logic              c_ovf, c_neg, c_unf;
  logic [2:0]        flg_q, flg_d;
  logic              stk_q, stk_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic              vld_q, vld_d;
  logic              acc_en, flg_en, stk_en, res_en;

  fxp_mac_mul #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mul (
    .x_i(x_in), .y_i(y_in), .x_sgn_i(x_signed), .y_sgn_i(y_signed),
    .frac_i(frac), .prod_o(prod)
  );

  always_comb begin
    case (op)
      MOP_MUL: base = prod;
      MOP_MAC: base = acc_q + prod;
      MOP_MSB: base = acc_q - prod;
      default: base = acc_q;
    endcase
  end

  fxp_mac_cond #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_cond (
    .val_i(base), .rnd_i(do_rnd), .sat_i(do_sat), .frac_i(frac),
    .sgn_i(x_signed), .res_o(cond_res), .word_o(cond_word),
    .ovf_o(c_ovf), .neg_o(c_neg), .unf_o(c_unf)
  );

  fxp_mac_port #(.DATA_W(DATA_W), .TOP_W(TOP_W), .ACC_W(ACC_W)) u_port (
    .acc_i(acc_q), .wr_en_i(wr_en && !op_valid), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .acc_o(port_acc), .rd_o(rd_data)
  );

  // next-state
  always_comb begin
    acc_en = clr || (arith && to_reg) || (wr_en && !op_valid);
    acc_d  = clr ? '0 : (arith ? cond_res : port_acc);

    flg_en = arith || clr || stat_wr_en;
    if (stat_wr_en)
      flg_d = {stat_wr_data[FLG_UNF], stat_wr_data[FLG_OVF], stat_wr_data[FLG_NEG]};
    else if (clr)
      flg_d = 3'b000;
    else
      flg_d = {c_unf, c_ovf, c_neg};

    stk_en = stky_wr_en || (arith && c_ovf);
    stk_d  = stky_wr_en ? stky_wr_data[STK_OVF] : 1'b1;

    res_en = arith || clr;
    res_d  = clr ? '0 : cond_word;
    vld_d  = arith || clr;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q <= '0;
      flg_q <= '0;
      stk_q <= 1'b0;
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (acc_en) acc_q <= acc_d;
      if (flg_en) flg_q <= flg_d;
      if (stk_en) stk_q <= stk_d;
      if (res_en) res_q <= res_d;
      vld_q <= vld_d;
    end
  end

  always_comb begin
    flags_out          = '0;
    flags_out[FLG_NEG] = flg_q[0];
    flags_out[FLG_OVF] = flg_q[1];
    flags_out[FLG_UNF] = flg_q[2];
    sticky_out          = '0;
    sticky_out[STK_OVF] = stk_q;
  end
  assign res_out = res_q;
  assign res_vld = vld_q;

  logic unused_bits;
  assign unused_bits = ^{stat_wr_data, stky_wr_data};

  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr && !stat_wr_en) |=> (acc_q == '0 && flg_q == 3'b000 && res_q == '0));

  // R4
  keep_reg_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && !to_reg && op_code != 3'd4) |=> $stable(acc_q));

  // R12
  mid_ext_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!op_valid && wr_en && wr_sel == 2'd1) |=>
      (acc_q[ACC_W-1:2*DATA_W] == {TOP_W{$past(wr_data[DATA_W-1])}}));

  // R12
  lo_noext_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!op_valid && wr_en && wr_sel == 2'd0) |=>
      (acc_q[ACC_W-1:DATA_W] == $past(acc_q[ACC_W-1:DATA_W])));

  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stk_q && !stky_wr_en) |=> stk_q);

  // R6
  rnd_low_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_code == 3'd5 && frac && to_reg) |=> (acc_q[DATA_W-1:0] == '0));

  // R13
  nop_vld_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!op_valid || op_code == 3'd0 || op_code == 3'd7) |=> !res_vld);

endmodule

// File: tb/fxp_mac_acc_tb.sv
`timescale 1ns/1ps
module fxp_mac_acc_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, to_reg, x_signed, y_signed, frac, rnd_req;
  logic [2:0]  op_code;
  logic [31:0] x_in, y_in, wr_data, rd_data, res_out;
  logic        wr_en, stat_wr_en, stky_wr_en, res_vld;
  logic [1:0]  wr_sel, rd_sel;
  logic [8:0]  stat_wr_data, stky_wr_data, flags_out, sticky_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fxp_mac_acc u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .to_reg(to_reg), .x_signed(x_signed), .y_signed(y_signed), .frac(frac),
    .rnd_req(rnd_req), .x_in(x_in), .y_in(y_in), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
    .stky_wr_en(stky_wr_en), .stky_wr_data(stky_wr_data),
    .flags_out(flags_out), .sticky_out(sticky_out),
    .res_out(res_out), .res_vld(res_vld)
  );

  // reference state
  logic [79:0] m_acc;
  logic [2:0]  m_flg;
  logic        m_stk;
  logic [31:0] m_res;
  logic        m_vld;

  task automatic chk(input string tag, input string what,
                     input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic signed [127:0] s80(input logic [79:0] v);
    return {{48{v[79]}}, v};
  endfunction

  task automatic model_next(output logic [79:0] na, output logic [2:0] nf,
                            output logic ns, output logic [31:0] nr, output logic nv);
    logic signed [127:0] ax, ay, p, v, q, rem, t, lo_lim, hi_lim, half;
    logic [79:0] pre, cand;
    logic [31:0] word;
    logic ov, un;
    int nb;
    na = m_acc; nf = m_flg; ns = m_stk; nr = m_res; nv = 1'b0;
    if (op_valid && op_code == 3'd4) begin
      na = '0; nf = '0; nr = '0; nv = 1'b1;
    end else if (op_valid && op_code inside {3'd1, 3'd2, 3'd3, 3'd5, 3'd6}) begin
      ax = x_signed ? {{96{x_in[31]}}, x_in} : {96'd0, x_in};
      ay = y_signed ? {{96{y_in[31]}}, y_in} : {96'd0, y_in};
      p  = ax * ay;
      if (frac && x_signed && y_signed) p = p * 2;
      case (op_code)
        3'd1:    v = s80(p[79:0]);
        3'd2:    v = s80(m_acc) + s80(p[79:0]);
        3'd3:    v = s80(m_acc) - s80(p[79:0]);
        default: v = s80(m_acc);
      endcase
      v   = s80(v[79:0]);
      pre = v[79:0];
      half = 128'sd1 <<< 31;
      if (frac && (op_code == 3'd5 || (rnd_req && op_code inside {3'd1, 3'd2, 3'd3}))) begin
        q   = v >>> 32;
        rem = v - (q <<< 32);
        if (rem > half || (rem == half && q[0])) q = q + 1;
        t = q <<< 32;
        v = s80(t[79:0]);
      end
      nb = frac ? 64 : 32;
      if (x_signed) begin
        hi_lim = (128'sd1 <<< (nb - 1)) - 1;
        lo_lim = -(128'sd1 <<< (nb - 1));
      end else begin
        hi_lim = (128'sd1 <<< nb) - 1;
        lo_lim = 128'sd0;
      end
      ov = (v < lo_lim) || (v > hi_lim);
      if (op_code == 3'd6 && ov) v = (x_signed && v < 0) ? lo_lim : hi_lim;
      cand = v[79:0];
      word = frac ? cand[63:32] : cand[31:0];
      un   = frac && (word == 32'd0) && (pre[31:0] != 32'd0);
      nf   = {un, ov, cand[79]};
      ns   = m_stk | ov;
      nr   = word;
      nv   = 1'b1;
      if (to_reg) na = cand;
    end else if (!op_valid && wr_en) begin
      case (wr_sel)
        2'd0: na[31:0] = wr_data;
        2'd1: begin na[63:32] = wr_data; na[79:64] = {16{wr_data[31]}}; end
        2'd2: na[79:64] = wr_data[15:0];
        default: ;
      endcase
    end
    if (stat_wr_en) nf = {stat_wr_data[8], stat_wr_data[7], stat_wr_data[6]};
    if (stky_wr_en) ns = stky_wr_data[6];
  endtask

  task automatic idle();
    op_valid = 0; op_code = 0; to_reg = 0; x_signed = 0; y_signed = 0;
    frac = 0; rnd_req = 0; x_in = 0; y_in = 0; wr_en = 0; wr_sel = 0;
    wr_data = 0; stat_wr_en = 0; stat_wr_data = 0; stky_wr_en = 0;
    stky_wr_data = 0; rd_sel = 0;
  endtask

  // one clock: model, edge, compare outputs and all sub-words
  task automatic step(input string tag);
    logic [79:0] na; logic [2:0] nf; logic ns; logic [31:0] nr; logic nv;
    model_next(na, nf, ns, nr, nv);
    @(posedge clk); #1;
    m_acc = na; m_flg = nf; m_stk = ns; m_res = nr; m_vld = nv;
    chk(tag, "flags", flags_out, {m_flg, 6'b0});
    chk(tag, "sticky", sticky_out, {2'b0, m_stk, 6'b0});
    chk(tag, "res_vld", res_vld, m_vld);
    chk(tag, "res_out", res_out, m_res);
    rd_sel = 2'd0; #0.3; chk(tag, "rd lo", rd_data, m_acc[31:0]);
    rd_sel = 2'd1; #0.3; chk(tag, "rd mid", rd_data, m_acc[63:32]);
    rd_sel = 2'd2; #0.3; chk(tag, "rd top", rd_data, {{16{m_acc[79]}}, m_acc[79:64]});
    rd_sel = 2'd3; #0.3; chk(tag, "rd none", rd_data, 32'd0);
    idle();
  endtask

  task automatic rd_now(input logic [1:0] s, output logic [31:0] d);
    rd_sel = s; #0.25; d = rd_data;
  endtask

  task automatic op(input string tag, input logic [2:0] c, input bit tr, input bit xs,
                    input bit ys, input bit fr, input bit rn,
                    input logic [31:0] a, input logic [31:0] b);
    op_valid = 1; op_code = c; to_reg = tr; x_signed = xs; y_signed = ys;
    frac = fr; rnd_req = rn; x_in = a; y_in = b;
    step(tag);
  endtask

  task automatic wr(input string tag, input logic [1:0] s, input logic [31:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    step(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    idle();
    m_acc = '0; m_flg = '0; m_stk = 0; m_res = '0; m_vld = 0;
    rst_n = 0;
    #9;
    // R1 reset state
    chk("R1", "flags", flags_out, 0);
    chk("R1", "sticky", sticky_out, 0);
    chk("R1", "res_vld", res_vld, 0);
    chk("R1", "res_out", res_out, 0);
    rd_sel = 0; #0.3; chk("R1", "rd lo", rd_data, 0);
    rd_sel = 1; #0.3; chk("R1", "rd mid", rd_data, 0);
    rd_sel = 2; #0.3; chk("R1", "rd top", rd_data, 0);
    rd_sel = 0;
    #2; rst_n = 1;
    repeat (3) @(posedge clk);
    #1;

    // R2 products in each format
    op("R2", 3'd1, 1, 1, 1, 0, 0, 32'd3, 32'hFFFF_FFFB);
    op("R2", 3'd1, 1, 1, 1, 1, 0, 32'h4000_0000, 32'h4000_0000);
    chk("R2", "half*half", res_out, 32'h2000_0000);
    op("R2", 3'd1, 1, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    op("R2", 3'd1, 1, 0, 0, 1, 0, 32'hFFFF_FFFF, 32'h8000_0000);
    op("R2", 3'd1, 1, 1, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

    // R4 result without register write
    op("R4", 3'd1, 0, 0, 0, 0, 0, 32'd7, 32'd9);
    chk("R4", "word", res_out, 32'd63);

    // R3 / R7 / R8 chains for each sign/format pair
    for (int c = 0; c < 4; c++) begin
      bit xs, fr;
      logic [31:0] big;
      xs = c[0]; fr = c[1];
      big = xs ? 32'h7FFF_FFF0 : 32'hFFFF_FFF0;
      op("R5", 3'd4, 0, xs, xs, fr, 0, 0, 0);
      for (int k = 0; k < 4; k++) op("R3", 3'd2, 1, xs, xs, fr, 0, big, big);
      op("R7", 3'd6, 1, xs, xs, fr, 0, 0, 0);
      for (int k = 0; k < 8; k++) op("R3", 3'd3, 1, xs, xs, fr, 0, big, big);
      op("R8", 3'd6, 1, xs, xs, fr, 0, 0, 0);
    end

    // R7 explicit limits
    op("R5", 3'd4, 1, 0, 0, 0, 0, 0, 0);
    op("R8", 3'd1, 1, 1, 1, 1, 0, 32'h8000_0000, 32'h8000_0000);
    chk("R8", "ovf flag", flags_out[7], 1'b1);
    op("R7", 3'd6, 1, 1, 1, 1, 0, 0, 0);
    rd_now(2'd1, d); chk("R7", "sf pos mid", d, 32'h7FFF_FFFF);
    rd_now(2'd0, d); chk("R7", "sf pos lo", d, 32'hFFFF_FFFF);
    rd_now(2'd2, d); chk("R7", "sf pos top", d, 32'h0);
    op("R5", 3'd4, 1, 0, 0, 0, 0, 0, 0);
    op("R3", 3'd3, 1, 1, 1, 0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    op("R7", 3'd6, 1, 1, 1, 0, 0, 0, 0);
    rd_now(2'd0, d); chk("R7", "si neg lo", d, 32'h8000_0000);
    rd_now(2'd1, d); chk("R7", "si neg mid", d, 32'hFFFF_FFFF);
    rd_now(2'd2, d); chk("R13", "top sign fill", d, 32'hFFFF_FFFF);
    chk("R10", "sticky", sticky_out[6], 1'b1);

    // R6 round ties and integer no-op
    wr("R12", 2'd0, 32'h8000_0000);
    wr("R12", 2'd1, 32'h0000_0002);
    op("R6", 3'd5, 1, 1, 1, 1, 0, 0, 0);
    rd_now(2'd1, d); chk("R6", "tie even", d, 32'h0000_0002);
    wr("R12", 2'd0, 32'h8000_0000);
    wr("R12", 2'd1, 32'h0000_0003);
    op("R6", 3'd5, 1, 1, 1, 1, 0, 0, 0);
    rd_now(2'd1, d); chk("R6", "tie odd", d, 32'h0000_0004);
    wr("R12", 2'd0, 32'h8000_0001);
    op("R6", 3'd5, 1, 1, 1, 0, 0, 0, 0);
    rd_now(2'd0, d); chk("R6", "int unchanged", d, 32'h8000_0001);
    op("R6", 3'd2, 1, 1, 1, 1, 1, 32'h0000_C000, 32'h0001_0000);

    // R9 underflow
    op("R9", 3'd1, 1, 1, 1, 1, 0, 32'd1, 32'd1);
    chk("R9", "unf flag", flags_out, 9'h100);

    // R11 overrides
    stat_wr_en = 1; stat_wr_data = 9'h040;
    op("R11", 3'd1, 1, 1, 1, 1, 0, 32'h8000_0000, 32'h8000_0000);
    chk("R11", "status write wins", flags_out, 9'h040);
    stky_wr_en = 1; stky_wr_data = 9'h000;
    step("R11");
    chk("R11", "sticky cleared", sticky_out, 9'h000);

    // R12 write ignored during an operation; guard word write
    op_valid = 1; op_code = 3'd0; wr_en = 1; wr_sel = 2'd0; wr_data = 32'h1234_5678;
    step("R12");
    wr("R12", 2'd2, 32'hABCD_8001);
    rd_now(2'd2, d); chk("R13", "top read", d, 32'hFFFF_8001);
    op("R13", 3'd7, 1, 1, 1, 0, 0, 32'd5, 32'd5);

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      op_valid = ($urandom % 4) != 0;
      op_code  = 3'($urandom % 8);
      to_reg   = 1'($urandom % 2);
      x_signed = 1'($urandom % 2);
      y_signed = ($urandom % 3) == 0 ? ~x_signed : x_signed;
      frac     = 1'($urandom % 2);
      rnd_req  = 1'($urandom % 2);
      x_in     = $urandom;
      y_in     = ($urandom % 4 == 0) ? 32'($urandom % 16) : $urandom;
      wr_en    = 1'($urandom % 2);
      wr_sel   = 2'($urandom % 4);
      wr_data  = $urandom;
      stat_wr_en = ($urandom % 16) == 0;
      stat_wr_data = 9'($urandom);
      stky_wr_en = ($urandom % 16) == 0;
      stky_wr_data = 9'($urandom);
      step("R3");
    end

    finish_run();
  end
endmodule